// File: doc/BRIEF.md
# Hard-Decision Axis Selector with Decision Witness

This block sits in the sample domain just ahead of a bit-recovery stage. On each valid strobe it takes a signed I/Q pair and uses a two-bit mode to pick the component and polarity that feeds the hard decision. It registers the picked sample and its sign-derived decision bit and sends both downstream with a valid flag. Negation saturates, so it never wraps.

Alongside the datapath it keeps a packed 32-bit witness word for software. The word holds three wrapping event counters and four sticky flags. The counters count transmit-valid strobes, recovered-bit valid pulses and recovered ones. The flags record whether the decision input was ever non-zero or ever negative, and whether the recovered stream ever pulsed or ever carried a one. With these, software can tell a dead receive path from one that delivers only zero bits. A burst-start pulse clears the whole witness. The recovered-bit inputs come back from the downstream bit-recovery stage.

Top module: `axis_decision_witness`

## Requirements
- R1: The mode picks the decision input. 0 gives I, 1 gives −I, 2 gives Q and 3 gives −Q. On a valid sample, the picked value appears on `decSample` one clock later with `decValid` high. Without a valid sample, `decValid` is low on the next clock.
- R2: Negating the most negative code gives the most positive code (for 12 bits, −2048 becomes +2047). No other value saturates.
- R3: `decBit` is 1 when the picked value is negative and 0 otherwise, including zero. It appears in the same cycle as `decSample`.
- R4: Witness bits 11:0 count `txValid` strobes since the last burst start and wrap modulo 4096.
- R5: Witness bits 19:12 count recovered bits equal to 1 and wrap modulo 256. A bit counts only when `recBitValid` is high.
- R6: Witness bits 27:20 count `recBitValid` pulses and wrap modulo 256.
- R7: Witness bit 28 is sticky. It sets when a valid sample gives a non-zero picked value.
- R8: Witness bit 29 is sticky. It sets when a valid sample gives a negative picked value.
- R9: Witness bit 30 is sticky and sets on any valid recovered 1. Witness bit 31 is sticky and sets on any `recBitValid` pulse.
- R10: A `burstStart` pulse zeroes the whole witness on the next clock. It wins over any event in the same cycle.
- R11: After reset, the witness, `decValid`, `decSample` and `decBit` are all zero.
- R12: When `sampleValid` is low, `decSample` and `decBit` hold their values and bits 28 and 29 do not change, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstStart | input | 1 | One-cycle pulse that clears the witness |
| mode | input | 2 | Axis and polarity select (0 I, 1 −I, 2 Q, 3 −Q) |
| sampleValid | input | 1 | Qualifies sampleI and sampleQ |
| sampleI | input | SAMPLE_W | Signed in-phase sample |
| sampleQ | input | SAMPLE_W | Signed quadrature sample |
| txValid | input | 1 | Transmit-side valid strobe being counted |
| recBitValid | input | 1 | Recovered-bit valid pulse from the bit stage |
| recBit | input | 1 | Recovered bit value |
| decValid | output | 1 | Registered valid for the decision outputs |
| decSample | output | SAMPLE_W | Selected, possibly negated, sample |
| decBit | output | 1 | Hard decision, 1 when the selected sample is negative |
| witness | output | 32 | Packed counters and sticky flags |

## Verification
The bench drives every 12-bit code through all four modes and computes each expected selection and decision arithmetically. This sweep covers the −2048 code under negation. A design that wraps at that code would output −2048 with a decision of 1. A design that treats zero as negative would flip `decBit` on every zero sample. The counters run past their field widths to catch a missing wrap or a field that spills into its neighbour. One case sends recovered ones with no valid strobe, and a counter that ignores the strobe would report too many ones. Further cases apply a burst start together with an event and send negative samples with no valid strobe. These catch a clear that loses to a same-cycle event, and a sticky flag that sets on an unqualified sample.

// File: rtl/axsel_pkg.sv
package axsel_pkg;

  typedef enum logic [1:0] {
    AX_I     = 2'd0,
    AX_NEG_I = 2'd1,
    AX_Q     = 2'd2,
    AX_NEG_Q = 2'd3
  } axisMode_t;

  localparam int WIT_W       = 32;
  localparam int TX_FIELD_W  = 12;
  localparam int ONE_FIELD_W = 8;
  localparam int VAL_FIELD_W = 8;
  localparam int ONE_LSB     = TX_FIELD_W;
  localparam int VAL_LSB     = ONE_LSB + ONE_FIELD_W;
  localparam int FLAG_LSB    = VAL_LSB + VAL_FIELD_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;        // zero the witness
    logic takeSample;   // load the decision register
    logic noteSample;   // update decision-input flags
    logic bumpTx;       // advance transmit-valid counter
    logic bumpRecValid; // advance recovered-valid counter
    logic bumpRecOne;   // advance recovered-one counter
  } selStrobe_t;

endpackage

// File: rtl/axsel_ctrl.sv
module axsel_ctrl
  import axsel_pkg::*;
(
  input  logic       burstStart,
  input  logic       sampleValid,
  input  logic       txValid,
  input  logic       recBitValid,
  input  logic       recBit,
  output selStrobe_t strobe
);

  // Clear has priority: every witness update is masked during a burst start.
  // The decision register keeps running across the clear.
  always_comb begin
    strobe.clear        = burstStart;
    strobe.takeSample   = sampleValid;
    strobe.noteSample   = sampleValid && !burstStart;
    strobe.bumpTx       = txValid && !burstStart;
    strobe.bumpRecValid = recBitValid && !burstStart;
    strobe.bumpRecOne   = recBitValid && recBit && !burstStart;
  end

endmodule

// File: rtl/axsel_datapath.sv
module axsel_datapath
  import axsel_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  selStrobe_t          strobe,
  input  logic [1:0]          mode,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  output logic                decValid,
  output logic [SAMPLE_W-1:0] decSample,
  output logic                decBit,
  output logic [WIT_W-1:0]    witness
);

  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MAX_CODE = {1'b0, {(SAMPLE_W-1){1'b1}}};

  axisMode_t axisSel;
  logic [SAMPLE_W-1:0] rawAxis;
  logic [SAMPLE_W-1:0] picked;

  // Saturating two's-complement negation
  function automatic logic [SAMPLE_W-1:0] satNeg(input logic [SAMPLE_W-1:0] v);
    if (v == MIN_CODE) return MAX_CODE;
    return (~v) + 1'b1;
  endfunction

  always_comb begin
    axisSel = axisMode_t'(mode);
    rawAxis = (axisSel == AX_Q || axisSel == AX_NEG_Q) ? sampleQ : sampleI;
    picked  = (axisSel == AX_NEG_I || axisSel == AX_NEG_Q) ? satNeg(rawAxis) : rawAxis;
  end

  // Decision register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decSample <= '0;
      decBit    <= 1'b0;
    end else begin
      decValid <= strobe.takeSample;
      if (strobe.takeSample) begin
        decSample <= picked;
        decBit    <= picked[SAMPLE_W-1];
      end
    end
  end

  // Witness counters
  logic [TX_FIELD_W-1:0]  txCnt;
  logic [ONE_FIELD_W-1:0] oneCnt;
  logic [VAL_FIELD_W-1:0] valCnt;
  logic nonzeroSeen, negSeen, oneSeen, validSeen;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      txCnt  <= '0;
      oneCnt <= '0;
      valCnt <= '0;
    end else begin
      if (strobe.bumpTx)       txCnt  <= txCnt + 1'b1;
      if (strobe.bumpRecOne)   oneCnt <= oneCnt + 1'b1;
      if (strobe.bumpRecValid) valCnt <= valCnt + 1'b1;
    end
  end

  // Sticky flags
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      nonzeroSeen <= 1'b0;
      negSeen     <= 1'b0;
      oneSeen     <= 1'b0;
      validSeen   <= 1'b0;
    end else begin
      if (strobe.noteSample && (picked != '0))     nonzeroSeen <= 1'b1;
      if (strobe.noteSample && picked[SAMPLE_W-1]) negSeen     <= 1'b1;
      if (strobe.bumpRecOne)                       oneSeen     <= 1'b1;
      if (strobe.bumpRecValid)                     validSeen   <= 1'b1;
    end
  end

  always_comb begin
    witness = '0;
    witness[TX_FIELD_W-1:0]            = txCnt;
    witness[ONE_LSB +: ONE_FIELD_W]    = oneCnt;
    witness[VAL_LSB +: VAL_FIELD_W]    = valCnt;
    witness[FLAG_LSB]                  = nonzeroSeen;
    witness[FLAG_LSB+1]                = negSeen;
    witness[FLAG_LSB+2]                = oneSeen;
    witness[FLAG_LSB+3]                = validSeen;
  end

  // R2: a negating mode never produces the most negative code
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeSample && mode[0]) |=> (decSample != MIN_CODE));

  // R10: a burst start leaves an all-zero witness
  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (witness == '0));

  // R8: the negative flag stays set until a clear
  p_neg_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (witness[FLAG_LSB+1] && !strobe.clear) |=> witness[FLAG_LSB+1]);

  // R7: a negative input is also a non-zero input
  p_neg_implies_nz_r7: assert property (@(posedge clk) disable iff (!rstN)
    witness[FLAG_LSB+1] |-> witness[FLAG_LSB]);

  // R9: a recovered one implies a recovered valid pulse
  p_one_implies_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    witness[FLAG_LSB+2] |-> witness[FLAG_LSB+3]);

  // R12: no valid sample, decision outputs hold
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeSample |=> ($stable(decSample) && $stable(decBit) && !decValid));

endmodule

// File: rtl/axis_decision_witness.sv
module axis_decision_witness
  import axsel_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                burstStart,
  input  logic [1:0]          mode,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  input  logic                txValid,
  input  logic                recBitValid,
  input  logic                recBit,
  output logic                decValid,
  output logic [SAMPLE_W-1:0] decSample,
  output logic                decBit,
  output logic [31:0]         witness
);

  selStrobe_t strobe;

  axsel_ctrl uCtrl (
    .burstStart  (burstStart),
    .sampleValid (sampleValid),
    .txValid     (txValid),
    .recBitValid (recBitValid),
    .recBit      (recBit),
    .strobe      (strobe)
  );

  axsel_datapath #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mode      (mode),
    .sampleI   (sampleI),
    .sampleQ   (sampleQ),
    .decValid  (decValid),
    .decSample (decSample),
    .decBit    (decBit),
    .witness   (witness)
  );

endmodule

// File: tb/sim_axis_decision_witness.sv
module sim_axis_decision_witness;

  localparam int W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstStart = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sampleValid = 1'b0;
  logic [W-1:0] sampleI = '0;
  logic [W-1:0] sampleQ = '0;
  logic txValid = 1'b0;
  logic recBitValid = 1'b0;
  logic recBit = 1'b0;
  logic decValid;
  logic [W-1:0] decSample;
  logic decBit;
  logic [31:0] witness;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  axis_decision_witness #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .mode(mode),
    .sampleValid(sampleValid), .sampleI(sampleI), .sampleQ(sampleQ),
    .txValid(txValid), .recBitValid(recBitValid), .recBit(recBit),
    .decValid(decValid), .decSample(decSample), .decBit(decBit),
    .witness(witness)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sDec, expSel, expOut, lastDec;
    #1;
    cyc(); cyc();
    rstN = 1'b1;
    cyc();
    // R11 reset state
    check(witness == 0, "R11 witness", witness, 0);
    check(decValid == 0 && decSample == 0 && decBit == 0, "R11 decision", decSample, 0);

    // R1 R2 R3 exhaustive sweep over codes and modes
    for (int m = 0; m < 4; m++) begin
      for (int v = -2048; v < 2048; v++) begin
        mode = m[1:0];
        sampleValid = 1'b1;
        sampleI = v[W-1:0];
        sampleQ = ~v[W-1:0];
        cyc();
        expSel = (m >= 2) ? (-v - 1) : v;
        expOut = expSel;
        if (m % 2 == 1) expOut = (expSel == -2048) ? 2047 : -expSel;
        sDec = $signed(decSample);
        if (expSel == -2048 && m % 2 == 1)
          check(sDec == expOut, "R2 saturation", sDec, expOut);
        else
          check(sDec == expOut && decValid, "R1 selection", sDec, expOut);
        check(decBit == (expOut < 0), "R3 decision", decBit, expOut < 0);
      end
    end

    // R10 clear, then R4 R5 R6 counting with quiet zero samples
    sampleValid = 1'b0;
    burstStart = 1'b1;
    cyc();
    burstStart = 1'b0;
    check(witness == 0, "R10 clear", witness, 0);
    for (int k = 0; k < 4100; k++) begin
      txValid = 1'b1;
      recBitValid = (k < 300);
      recBit = (k % 3 == 0);
      mode = 2'd0;
      sampleValid = 1'b1;
      sampleI = '0;
      sampleQ = '0;
      cyc();
    end
    txValid = 1'b0; recBitValid = 1'b0; sampleValid = 1'b0;
    // recovered ones without valid must not count (R5)
    for (int k = 0; k < 20; k++) begin
      recBit = 1'b1;
      cyc();
    end
    recBit = 1'b0;
    check(witness[11:0] == 12'd4, "R4 tx count wrap", witness[11:0], 4);
    check(witness[19:12] == 8'd100, "R5 ones count", witness[19:12], 100);
    check(witness[27:20] == 8'd44, "R6 valid count wrap", witness[27:20], 44);
    check(witness[31:30] == 2'b11, "R9 stream flags", witness[31:30], 3);
    check(witness[29:28] == 2'b00, "R7 zero inputs leave flags", witness[29:28], 0);

    // R12 negative input without valid is ignored
    lastDec = $signed(decSample);
    sampleI = 12'hFF9;
    sampleQ = 12'h800;
    mode = 2'd0;
    sampleValid = 1'b0;
    cyc(); cyc();
    check($signed(decSample) == lastDec && !decValid, "R12 hold", $signed(decSample), lastDec);
    check(witness[29:28] == 2'b00, "R12 flags untouched", witness[29:28], 0);

    // R7 R8: mode 1 with positive I gives a negative decision input
    mode = 2'd1;
    sampleI = 12'd5;
    sampleValid = 1'b1;
    cyc();
    sampleValid = 1'b0;
    check($signed(decSample) == -5 && decBit, "R1 neg I", $signed(decSample), -5);
    check(witness[29:28] == 2'b11, "R8 neg flag", witness[29:28], 3);
    cyc();
    check(witness[29:28] == 2'b11, "R8 sticky", witness[29:28], 3);

    // R10 priority over same-cycle events
    burstStart = 1'b1;
    txValid = 1'b1;
    recBitValid = 1'b1;
    recBit = 1'b1;
    sampleValid = 1'b1;
    mode = 2'd3;
    sampleQ = 12'd9;
    cyc();
    burstStart = 1'b0; txValid = 1'b0; recBitValid = 1'b0; recBit = 1'b0; sampleValid = 1'b0;
    check(witness == 0, "R10 clear wins", witness, 0);

    // R7 positive only sets non-zero flag
    mode = 2'd2;
    sampleQ = 12'd300;
    sampleValid = 1'b1;
    cyc();
    sampleValid = 1'b0;
    check(witness[29:28] == 2'b01, "R7 positive", witness[29:28], 1);
    check(decBit == 1'b0 && $signed(decSample) == 300, "R3 positive bit", decBit, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule